// File: doc/BRIEF.md
# Coherent Sample Burst Writer

This block takes a stream of 16-bit converter samples and writes them into a processor's coherency port over the write half of an AXI bus. The goal is for the samples to land in the shared second-level cache and not in backing memory. Software supplies a base address and a byte count, then pulses a start input. The block packs four samples into each 64-bit beat, lowest lane first. It sends short incrementing bursts that never cross a 32-byte cache line. When the last write response has come back, it raises a one-cycle completion pulse. Every acquisition reuses the same base address, so after the first pass the same cache lines are written again.

Each address beat marks the write as coherent (user sideband bit 0 set), cacheable and write-allocating, so a miss reserves a line. The lock attribute is never used, because the coherency unit drops it. If the last beat holds fewer than four samples, its byte strobes enable only the lanes that carry data. An error response, a malformed length, or a start while busy is handled as the requirements below describe.

Top module: `coh_sample_writer`

## Requirements
- R1: Every address beat carries awuser_o[0]=1, awcache_o=4'b1111 (bit 1 cacheable, bit 3 write-allocate), awlock_o=0, awburst_o=2'b01 (incrementing) and awsize_o=3'd3 (8-byte beats).
- R2: The first burst starts at base_i with its three low bits cleared. Each later burst starts at the byte right after the previous burst, and ceil(len_i/8) beats are written in total.
- R3: A burst never crosses a 32-byte line. awlen_o+1 equals the smaller of the beats still to send and the beats left before the end of the current line (4 minus awaddr_o[4:3]).
- R4: Samples fill a beat in arrival order. Sample k of a beat sits at wdata_o[16k+15:16k], for k = 0..3.
- R5: wstrb_o has two bits per sample lane, lowest lane first. A beat with n samples has exactly the low 2n strobe bits set, so only a partial final beat has fewer than 8.
- R6: In each burst the address beat is accepted before any data beat, wlast_o is high only on the beat numbered awlen_o, and no new address beat is issued until the previous burst's write response has been received.
- R7: done_o is high for exactly one cycle, in the cycle after the handshake of the final write response, and never earlier.
- R8: A write response with bresp_i not equal to 2'b00 sets err_o. The sequence still runs to completion with done_o. err_o stays set until the next start request is accepted while idle.
- R9: A start request while busy_o is high is ignored. The running sequence's addresses, data and completion are unchanged.
- R10: A start with an odd length, a length below 2, or a length above 65536 bytes sets err_o, leaves busy_o low, and produces no bus traffic and no done_o.
- R11: While reset is held and right after it, busy_o, done_o, err_o, awvalid_o, wvalid_o, bready_o and smp_ready_o are all 0.
- R12: smp_ready_o is high only while a beat of an open burst is being filled. Exactly len_i/2 samples are accepted per sequence, and none after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| base_i | input | 32 | Destination byte address |
| len_i | input | 17 | Transfer length in bytes |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky error flag (bad length or error response) |
| smp_valid_i | input | 1 | Sample available |
| smp_data_i | input | 16 | Sample value |
| smp_ready_o | output | 1 | Sample accepted when high together with smp_valid_i |
| awvalid_o | output | 1 | Write address valid |
| awready_i | input | 1 | Write address ready |
| awaddr_o | output | 32 | Burst start address |
| awlen_o | output | 8 | Beats in burst minus one |
| awsize_o | output | 3 | Beat size code |
| awburst_o | output | 2 | Burst type |
| awcache_o | output | 4 | Cache attributes |
| awlock_o | output | 1 | Lock attribute, always 0 |
| awuser_o | output | 1 | Coherency sideband |
| wvalid_o | output | 1 | Write data valid |
| wready_i | input | 1 | Write data ready |
| wdata_o | output | 64 | Packed samples |
| wstrb_o | output | 8 | Byte enables |
| wlast_o | output | 1 | Last beat of burst |
| bvalid_i | input | 1 | Write response valid |
| bready_o | output | 1 | Write response ready |
| bresp_i | input | 2 | Write response code |

## Verification
The hardest case to reach is a burst that starts partway through a line and ends on a partial beat, with an error response injected into a chosen burst. The stimulus gets there through a base address whose bits 4:3 are non-zero and whose low bits are junk, and a sample count that is not a multiple of four. The bus model is told which response index returns an error code. A second start is driven in the middle of a running sequence while the model is left unchanged, so any effect of that start shows up as an address or data mismatch. Stalls on the address and data ready lines, and gaps in the sample stream, keep the valid-hold and packing paths under pressure.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } swr_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [3:0] CACHE_WBWA = 4'b1111;
endpackage

// File: rtl/swr_burst_plan.sv
module swr_burst_plan #(
  parameter int CNT_W      = 17,
  parameter int LINE_BEATS = 4,
  parameter int IDX_W      = 2
) (
  input  logic [IDX_W-1:0] line_idx_i,
  input  logic [CNT_W-1:0] beats_left_i,
  output logic [CNT_W-1:0] burst_beats_o
);
  logic [CNT_W-1:0] room;

  assign room          = CNT_W'(LINE_BEATS) - CNT_W'(line_idx_i);
  assign burst_beats_o = (beats_left_i < room) ? beats_left_i : room;
endmodule

// File: rtl/swr_packer.sv
module swr_packer #(
  parameter int LANES  = 4,
  parameter int SMP_W  = 16,
  parameter int CNT_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     take_i,
  input  logic [SMP_W-1:0]         smp_i,
  output logic [LANES*SMP_W-1:0]   data_o,
  output logic [LANES*SMP_W/8-1:0] strb_o,
  output logic [CNT_W-1:0]         cnt_o
);
  localparam int BPS = SMP_W / 8;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)     cnt_d = '0;
    else if (take_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SMP_W-1:0] lane_q;
    logic             lane_en;

    assign lane_en = take_i && (cnt_q == CNT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_en) lane_q <= smp_i;
    end

    assign data_o[i*SMP_W +: SMP_W] = lane_q;
    assign strb_o[i*BPS +: BPS]     = {BPS{cnt_q > CNT_W'(i)}};
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/coh_sample_writer.sv
module coh_sample_writer
  import swr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int SMP_W      = 16,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 65536,
  localparam int LEN_W     = $clog2(MAX_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_data_i,
  output logic              smp_ready_o,
  output logic              awvalid_o,
  input  logic              awready_i,
  output logic [ADDR_W-1:0] awaddr_o,
  output logic [7:0]        awlen_o,
  output logic [2:0]        awsize_o,
  output logic [1:0]        awburst_o,
  output logic [3:0]        awcache_o,
  output logic              awlock_o,
  output logic [0:0]        awuser_o,
  output logic              wvalid_o,
  input  logic              wready_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W/8-1:0] wstrb_o,
  output logic              wlast_o,
  input  logic              bvalid_i,
  output logic              bready_o,
  input  logic [1:0]        bresp_i
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int SMP_BYTES  = SMP_W / 8;
  localparam int LANES      = DATA_W / SMP_W;
  localparam int LINE_BEATS = LINE_BYTES / BEAT_BYTES;
  localparam int AOFF       = $clog2(BEAT_BYTES);
  localparam int SOFF       = $clog2(SMP_BYTES);
  localparam int LIDX_W     = $clog2(LINE_BEATS);
  localparam int LCNT_W     = $clog2(LANES + 1);

  swr_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  beats_q, beats_d;
  logic [LEN_W-1:0]  burst_q, burst_d;
  logic [LEN_W-1:0]  smp_q, smp_d;
  logic              err_q, err_d;
  logic              done_q, done_d;

  logic [LEN_W-1:0]  plan_beats;
  logic [LCNT_W-1:0] lane_cnt;
  logic              len_ok, beat_full, take, aw_fire, w_fire, b_fire;

  swr_burst_plan #(.CNT_W(LEN_W), .LINE_BEATS(LINE_BEATS), .IDX_W(LIDX_W)) u_plan (
    .line_idx_i    (addr_q[AOFF +: LIDX_W]),
    .beats_left_i  (beats_q),
    .burst_beats_o (plan_beats)
  );

  swr_packer #(.LANES(LANES), .SMP_W(SMP_W), .CNT_W(LCNT_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (w_fire),
    .take_i  (take),
    .smp_i   (smp_data_i),
    .data_o  (wdata_o),
    .strb_o  (wstrb_o),
    .cnt_o   (lane_cnt)
  );

  assign len_ok    = (len_i[SOFF-1:0] == '0) && (len_i >= LEN_W'(SMP_BYTES)) &&
                     (len_i <= LEN_W'(MAX_BYTES));
  assign beat_full = (lane_cnt == LCNT_W'(LANES)) || ((smp_q == '0) && (lane_cnt != '0));

  assign smp_ready_o = (state_q == ST_DATA) && !beat_full;
  assign wvalid_o    = (state_q == ST_DATA) && beat_full;
  assign wlast_o     = (burst_q == LEN_W'(1));
  assign awvalid_o   = (state_q == ST_ADDR);
  assign bready_o    = (state_q == ST_RESP);

  assign take    = smp_valid_i && smp_ready_o;
  assign aw_fire = awvalid_o && awready_i;
  assign w_fire  = wvalid_o && wready_i;
  assign b_fire  = bvalid_i && bready_o;

  assign awaddr_o  = addr_q;
  assign awlen_o   = 8'(plan_beats - LEN_W'(1));
  assign awsize_o  = 3'(AOFF);
  assign awburst_o = BURST_INCR;
  assign awcache_o = CACHE_WBWA;
  assign awlock_o  = 1'b0;
  assign awuser_o  = 1'b1;

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    beats_d = beats_q;
    burst_d = burst_q;
    smp_d   = smp_q;
    err_d   = err_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (len_ok) begin
            err_d   = 1'b0;
            addr_d  = base_i & ~ADDR_W'(BEAT_BYTES - 1);
            smp_d   = len_i >> SOFF;
            beats_d = (len_i + LEN_W'(BEAT_BYTES - 1)) >> AOFF;
            state_d = ST_ADDR;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_ADDR: begin
        if (aw_fire) begin
          burst_d = plan_beats;
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (take) smp_d = smp_q - LEN_W'(1);
        if (w_fire) begin
          addr_d  = addr_q + ADDR_W'(BEAT_BYTES);
          beats_d = beats_q - LEN_W'(1);
          burst_d = burst_q - LEN_W'(1);
          if (burst_q == LEN_W'(1)) state_d = ST_RESP;
        end
      end
      ST_RESP: begin
        if (b_fire) begin
          if (bresp_i != RESP_OKAY) err_d = 1'b1;
          if (beats_q == '0) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_ADDR;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      beats_q <= '0;
      burst_q <= '0;
      smp_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      beats_q <= beats_d;
      burst_q <= burst_d;
      smp_q   <= smp_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/swr_checker.sv
module swr_checker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy_o,
  input logic                done_o,
  input logic                smp_ready_o,
  input logic                awvalid_o,
  input logic                awready_i,
  input logic [ADDR_W-1:0]   awaddr_o,
  input logic [7:0]          awlen_o,
  input logic [2:0]          awsize_o,
  input logic [1:0]          awburst_o,
  input logic [3:0]          awcache_o,
  input logic                awlock_o,
  input logic [0:0]          awuser_o,
  input logic                wvalid_o,
  input logic                wready_i,
  input logic [DATA_W-1:0]   wdata_o,
  input logic [DATA_W/8-1:0] wstrb_o,
  input logic                wlast_o,
  input logic                bvalid_i,
  input logic                bready_o
);
  localparam int AOFF       = $clog2(DATA_W / 8);
  localparam int LINE_BEATS = LINE_BYTES / (DATA_W / 8);
  localparam int LIDX_W     = $clog2(LINE_BEATS);

  logic [7:0] len_q, beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      beat_q <= '0;
    end else if (awvalid_o && awready_i) begin
      len_q  <= awlen_o;
      beat_q <= '0;
    end else if (wvalid_o && wready_i) begin
      beat_q <= beat_q + 8'd1;
    end
  end

  a_r1_coherent_attr: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid_o |-> (awuser_o[0] && awcache_o[1] && awcache_o[3] && !awlock_o &&
                   awburst_o == 2'b01 && awsize_o == 3'(AOFF)));

  a_r3_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid_o |-> ((32'(awaddr_o[AOFF +: LIDX_W]) + 32'(awlen_o)) < LINE_BEATS));

  a_r6_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid_o && !awready_i) |=> (awvalid_o && $stable(awaddr_o) && $stable(awlen_o)));

  a_r6_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid_o && !wready_i) |=> (wvalid_o && $stable(wdata_o) && $stable(wstrb_o) &&
                                 $stable(wlast_o)));

  a_r6_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid_o |-> (wlast_o == (beat_q == len_q)));

  a_r5_first_lane: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid_o |-> (wstrb_o[1:0] == 2'b11));

  a_r7_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bvalid_i && bready_o));

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r12_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready_o |-> (busy_o && !wvalid_o));
endmodule

bind coh_sample_writer swr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .smp_ready_o(smp_ready_o),
  .awvalid_o(awvalid_o), .awready_i(awready_i), .awaddr_o(awaddr_o), .awlen_o(awlen_o),
  .awsize_o(awsize_o), .awburst_o(awburst_o), .awcache_o(awcache_o), .awlock_o(awlock_o),
  .awuser_o(awuser_o), .wvalid_o(wvalid_o), .wready_i(wready_i), .wdata_o(wdata_o),
  .wstrb_o(wstrb_o), .wlast_o(wlast_o), .bvalid_i(bvalid_i), .bready_o(bready_o)
);

// File: tb/coh_sample_writer_test.sv
module coh_sample_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [16:0] len_i = '0;
  logic        busy_o, done_o, err_o;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_data_i = '0;
  logic        smp_ready_o;
  logic        awvalid_o;
  logic        awready_i = 1'b0;
  logic [31:0] awaddr_o;
  logic [7:0]  awlen_o;
  logic [2:0]  awsize_o;
  logic [1:0]  awburst_o;
  logic [3:0]  awcache_o;
  logic        awlock_o;
  logic [0:0]  awuser_o;
  logic        wvalid_o;
  logic        wready_i = 1'b0;
  logic [63:0] wdata_o;
  logic [7:0]  wstrb_o;
  logic        wlast_o;
  logic        bvalid_i = 1'b0;
  logic        bready_o;
  logic [1:0]  bresp_i = 2'b00;

  always #5 clk = ~clk;

  coh_sample_writer uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .smp_ready_o(smp_ready_o),
    .awvalid_o(awvalid_o), .awready_i(awready_i), .awaddr_o(awaddr_o), .awlen_o(awlen_o),
    .awsize_o(awsize_o), .awburst_o(awburst_o), .awcache_o(awcache_o),
    .awlock_o(awlock_o), .awuser_o(awuser_o),
    .wvalid_o(wvalid_o), .wready_i(wready_i), .wdata_o(wdata_o), .wstrb_o(wstrb_o),
    .wlast_o(wlast_o), .bvalid_i(bvalid_i), .bready_o(bready_o), .bresp_i(bresp_i)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // bus and source model state
  int cyc = 0;
  bit aw_stall = 0, w_stall = 0, src_gap = 0;
  int src_n = 0, src_i = 0;
  logic [15:0] seq_tag = 16'h0;
  logic [31:0] m_addr;
  int m_beats = 0, m_total = 0, m_idx = 0, m_burst = 0;
  int m_awcnt = 0, m_bcnt = 0, m_done = 0, bad_b = -1, b_pend = 0;
  bit b_fired = 0, prev_bf = 0;

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 263) ^ seq_tag;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      awready_i = !(aw_stall && (cyc % 3 != 0));
      wready_i  = !(w_stall && (cyc % 2 == 0));
      if (b_fired) begin
        bvalid_i = 1'b0;
        b_fired  = 0;
      end else if (b_pend > 0 && !bvalid_i) begin
        bvalid_i = 1'b1;
        bresp_i  = (m_bcnt == bad_b) ? 2'b10 : 2'b00;
      end
      smp_valid_i = (src_i < src_n) && !(src_gap && (cyc % 4 == 1));
      smp_data_i  = pat(src_i);
      #1;
      if (done_o) begin
        m_done++;
        check(prev_bf && m_bcnt == m_awcnt && m_idx == m_total, "R7",
              "done before final response", m_bcnt, m_awcnt);
      end
      if (smp_valid_i && smp_ready_o) src_i++;
      if (awvalid_o && awready_i) begin
        int room, n;
        room = 4 - int'((m_addr >> 3) & 32'd3);
        n = (m_beats < room) ? m_beats : room;
        check(awaddr_o == m_addr, "R2", "burst address", awaddr_o, m_addr);
        check(int'(awlen_o) == n - 1, "R3", "burst length", awlen_o, n - 1);
        check(awuser_o[0] && awcache_o == 4'b1111 && !awlock_o && awburst_o == 2'b01 &&
              awsize_o == 3'd3, "R1", "attributes",
              {awuser_o, awcache_o, awlock_o, awburst_o, awsize_o}, 11'b1_1111_0_01_011);
        m_burst = n;
        m_awcnt++;
      end
      if (wvalid_o && wready_i) begin
        int m;
        logic [7:0]  es;
        logic [63:0] mask, ed;
        m = (m_total - m_idx < 4) ? (m_total - m_idx) : 4;
        es = '0; mask = '0; ed = '0;
        for (int k = 0; k < m; k++) begin
          es[2*k +: 2]    = 2'b11;
          mask[16*k +: 16] = 16'hFFFF;
          ed[16*k +: 16]   = pat(m_idx + k);
        end
        check(m_burst > 0, "R6", "data beat outside burst", m_burst, 1);
        check(wstrb_o == es, "R5", "strobes", wstrb_o, es);
        check((wdata_o & mask) == ed, "R4", "packed data", wdata_o & mask, ed);
        check(wlast_o == (m_burst == 1), "R6", "wlast", wlast_o, m_burst == 1);
        m_idx += m;
        m_addr += 32'd8;
        m_beats--;
        m_burst--;
        if (wlast_o) b_pend++;
      end
      prev_bf = bvalid_i && bready_o;
      if (prev_bf) begin
        m_bcnt++;
        b_fired = 1;
        b_pend--;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic pulse_start(input logic [31:0] b, input int len);
    @(negedge clk);
    start_i = 1'b1;
    base_i  = b;
    len_i   = 17'(len);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic arm(input logic [31:0] b, input int len, input int bad);
    seq_tag = seq_tag + 16'h1357;
    src_i = 0;
    src_n = len / 2 + 2;
    m_addr = b & ~32'd7;
    m_beats = (len + 7) / 8;
    m_total = len / 2;
    m_idx = 0; m_burst = 0; m_awcnt = 0; m_bcnt = 0;
    bad_b = bad;
  endtask

  task automatic wait_done(input int d0);
    int k = 0;
    while (m_done == d0 && k < 100000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_seq(input string tag, input logic [31:0] b, input int len, input int bad);
    int d0 = m_done;
    arm(b, len, bad);
    pulse_start(b, len);
    wait_done(d0);
    repeat (3) @(negedge clk);
    #2;
    check(m_done == d0 + 1, "R7", {tag, " done count"}, m_done - d0, 1);
    check(m_beats == 0, "R2", {tag, " beats written"}, m_beats, 0);
    check(src_i == m_total, "R12", {tag, " samples taken"}, src_i, m_total);
    check(m_bcnt == m_awcnt, "R6", {tag, " responses"}, m_bcnt, m_awcnt);
    check(err_o == (bad >= 0), "R8", {tag, " error flag"}, err_o, bad >= 0);
    check(!busy_o && !smp_ready_o, "R12", {tag, " idle after done"}, {busy_o, smp_ready_o}, 0);
  endtask

  task automatic t_reset;
    #2;
    check(!busy_o && !done_o && !err_o && !awvalid_o && !wvalid_o && !bready_o && !smp_ready_o,
          "R11", "outputs in reset",
          {busy_o, done_o, err_o, awvalid_o, wvalid_o, bready_o, smp_ready_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!busy_o && !done_o && !err_o && !awvalid_o && !wvalid_o && !bready_o && !smp_ready_o,
          "R11", "outputs after reset",
          {busy_o, done_o, err_o, awvalid_o, wvalid_o, bready_o, smp_ready_o}, 0);
  endtask

  task automatic t_aligned;
    run_seq("aligned", 32'h0001_0000, 64, -1);
  endtask

  task automatic t_mid_line;
    // base bits 4:3 = 3, low bits junk (R2 masking, R3 split)
    run_seq("mid line", 32'h0000_101E, 40, -1);
    run_seq("mid line short", 32'h0000_2010, 26, -1);
  endtask

  task automatic t_partial;
    run_seq("one sample", 32'h0000_3000, 2, -1);
    run_seq("five samples", 32'h0000_3008, 10, -1);
    run_seq("seven samples", 32'h0000_3000, 14, -1);
  endtask

  task automatic t_stalls;
    aw_stall = 1; w_stall = 1; src_gap = 1;
    run_seq("stalled", 32'h0000_4008, 100, -1);
    aw_stall = 0; w_stall = 0; src_gap = 0;
  endtask

  task automatic t_bad_resp;
    run_seq("slverr", 32'h0000_5000, 96, 1);
    repeat (10) @(negedge clk);
    #2;
    check(err_o == 1'b1, "R8", "error sticky while idle", err_o, 1);
    run_seq("after error", 32'h0000_5000, 16, -1);
  endtask

  task automatic t_busy_start;
    int d0 = m_done;
    arm(32'h0000_6000, 48, -1);
    pulse_start(32'h0000_6000, 48);
    while (m_awcnt < 1) @(negedge clk);
    pulse_start(32'h0000_9000, 8);
    #2;
    check(busy_o == 1'b1, "R9", "still busy after second start", busy_o, 1);
    wait_done(d0);
    repeat (20) @(negedge clk);
    #2;
    check(m_done == d0 + 1, "R9", "single completion", m_done - d0, 1);
    check(m_beats == 0 && src_i == m_total, "R9", "original sequence intact", m_beats, 0);
    check(!busy_o, "R9", "idle after sequence", busy_o, 0);
  endtask

  task automatic t_bad_len;
    int lens[3] = '{7, 0, 65538};
    foreach (lens[i]) begin
      int d0 = m_done;
      arm(32'h0000_7000, 2, -1);
      pulse_start(32'h0000_7000, lens[i]);
      repeat (10) @(negedge clk);
      #2;
      check(err_o == 1'b1, "R10", "error on bad length", err_o, 1);
      check(!busy_o && m_awcnt == 0 && src_i == 0, "R10", "no activity on bad length",
            m_awcnt, 0);
      check(m_done == d0, "R10", "no done on bad length", m_done - d0, 0);
    end
    run_seq("clears error", 32'h0000_7000, 8, -1);
  endtask

  task automatic t_max_len;
    run_seq("max length", 32'h0002_0000, 65536, -1);
  endtask

  initial begin
    t_reset();
    t_aligned();
    t_mid_line();
    t_partial();
    t_stalls();
    t_bad_resp();
    t_busy_start();
    t_bad_len();
    t_max_len();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule